// File: doc/BRIEF.md
# Configuration Hold Checker

This block watches a configuration bus while a transaction runs and reports any cycle in which the bus changes value. It sits beside a controller in the design and in silicon, runs continuously, and raises flags that other logic or a test environment can observe. The checker only observes. It does not generate the protocol and does not hold the configuration.

A transaction window opens when `start` rises. The first cycle checked is the one after that edge. The last cycle checked is the cycle in which `done` is high. The comparison is skipped on the edge cycle itself, because on that cycle the bus is still allowed to settle from its previous value.

The parameter `BUSY_MODE` chooses what delimits the per-cycle check. It is either the start/done window or the `busy` level. The per-cycle report `viol` fires in the exact cycle the bus moves. The window report `win_fail` fires only when the start/done window closes. Both reports run side by side.

Top module: `cfg_hold_monitor`

## Requirements
- R1: While rst_n is low, viol and win_fail are 0 and err_sticky is cleared to 0.
- R2: A window opens only on a start edge, meaning start is 1 in this cycle and was 0 in the previous cycle. The window covers the cycles from the one after the edge up to and including the cycle where done is 1.
- R3: cfg is not compared on the cycle of the start edge, so a change on that cycle raises nothing.
- R4: With BUSY_MODE=0, in every window cycle where cfg differs from its value in the previous cycle, viol is 1 in that same cycle. viol is 0 in all other cycles.
- R5: With BUSY_MODE=1, viol is 1 in each cycle where busy is 1 and cfg differs from its previous-cycle value. Changes while busy is 0 do not raise viol.
- R6: win_fail is a one-cycle pulse on the done cycle that closes a window. It is raised only if cfg changed on at least one checked cycle of that window. This holds in both modes.
- R7: err_sticky becomes 1 in the cycle after any cycle with viol=1 and stays 1 until reset.
- R8: A start edge that arrives while a window is open is ignored. The window still closes at the next done.
- R9: A done with no open window is ignored and produces no win_fail.
- R10: The first cycle after reset is never compared, because no previous value exists yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Transaction start strobe; its rising edge opens a window |
| done | input | 1 | Transaction end; closes an open window in its cycle |
| busy | input | 1 | Level that delimits the per-cycle check when BUSY_MODE=1 |
| cfg | input | CFG_W | Configuration bus being watched |
| viol | output | 1 | High in each cycle the bus moves inside the checked scope |
| err_sticky | output | 1 | Set after any viol and held until reset |
| win_fail | output | 1 | One-cycle pulse on a closing done if the window saw a change |

## Verification
The bench changes cfg exactly on the start-edge cycle. A checker that compares there would raise a false viol. It holds start high across several cycles and pulses it again inside an open window. A design that treats a level as an edge, or that reopens the window, would then shift its checked range or clear the failure state. The bench also issues done without a window, changes cfg right after done, and changes it on the done cycle itself. These cases catch off-by-one window ends and win_fail pulses that are missing or stray. A second instance in busy mode checks that changes outside busy stay silent, while the window report still follows start/done. A mid-run reset checks that the sticky flag clears.

// File: rtl/cfg_hold_monitor.sv
module cfg_hold_monitor #(
  parameter int CFG_W     = 16,
  parameter bit BUSY_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             done,
  input  logic             busy,
  input  logic [CFG_W-1:0] cfg,
  output logic             viol,
  output logic             err_sticky,
  output logic             win_fail
);

  logic [CFG_W-1:0] cfg_q;
  logic prev_ok, start_q, win_open, win_bad;
  logic chg, start_edge, in_scope;

  assign chg        = prev_ok && (cfg != cfg_q);
  assign start_edge = start && !start_q;
  assign in_scope   = BUSY_MODE ? busy : win_open;
  assign viol       = rst_n && in_scope && chg;
  assign win_fail   = rst_n && win_open && done && (win_bad || chg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      prev_ok    <= 1'b0;
      start_q    <= 1'b0;
      win_open   <= 1'b0;
      win_bad    <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      cfg_q   <= cfg;
      prev_ok <= 1'b1;
      start_q <= start;
      if (viol) err_sticky <= 1'b1;
      if (win_open) begin
        if (done) begin
          win_open <= 1'b0;
          win_bad  <= 1'b0;
        end else if (chg) begin
          win_bad <= 1'b1;
        end
      end else if (start_edge) begin
        win_open <= 1'b1;
        win_bad  <= 1'b0;
      end
    end
  end

  // R1: outputs quiet while reset is held
  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (!viol && !win_fail));

  // R7: sticky flag follows any violation and then holds
  assert_sticky_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> err_sticky);
  assert_sticky_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  // R6: window report only on a done cycle, and only for one cycle
  assert_fail_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    win_fail |-> done);
  assert_fail_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    win_fail |=> !win_fail);

  // R4 / R5: a bus that holds still never raises viol
  assert_stable_no_viol_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ok && $stable(cfg)) |-> !viol);

  // R5: in busy mode nothing is flagged while busy is low
  assert_busy_scope_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (BUSY_MODE && !busy) |-> !viol);

endmodule

// File: tb/sim_cfg_hold_monitor.sv
module sim_cfg_hold_monitor;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, done = 1'b0, busy = 1'b0;
  logic [W-1:0] cfg = '0;
  logic v0, e0, f0, v1, e1, f1;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cfg_hold_monitor #(.CFG_W(W), .BUSY_MODE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .busy(busy),
    .cfg(cfg), .viol(v0), .err_sticky(e0), .win_fail(f0));
  cfg_hold_monitor #(.CFG_W(W), .BUSY_MODE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .busy(busy),
    .cfg(cfg), .viol(v1), .err_sticky(e1), .win_fail(f1));

  // reference model state
  int prev_cfg = 0;
  bit have_prev = 0, prev_start = 0, open = 0, bad = 0, st0 = 0, st1 = 0;

  task automatic chk(input logic act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit s, input bit d, input bit b, input int c);
    bit chg, ev0, ev1, ef;
    @(negedge clk);
    rst_n = r; start = s; done = d; busy = b; cfg = c[W-1:0];
    #1;
    if (!r) begin
      have_prev = 0; prev_start = 0; open = 0; bad = 0; st0 = 0; st1 = 0;
      chk(v0, 0, "R1 viol u0"); chk(v1, 0, "R1 viol u1");
      chk(f0, 0, "R1 win_fail"); chk(e0, 0, "R1 sticky u0"); chk(e1, 0, "R1 sticky u1");
      return;
    end
    chg = have_prev && (c != prev_cfg);
    ev0 = open && chg;
    ev1 = b && chg;
    ef  = open && d && (bad || chg);
    chk(v0, ev0, "R4 viol u0");
    chk(v1, ev1, "R5 viol u1");
    chk(f0, ef, "R6 win_fail u0");
    chk(f1, ef, "R6 win_fail u1");
    chk(e0, st0, "R7 sticky u0");
    chk(e1, st1, "R7 sticky u1");
    st0 |= ev0; st1 |= ev1;
    if (open) begin
      if (d) begin open = 0; bad = 0; end
      else if (chg) bad = 1;
    end else if (s && !prev_start) begin
      open = 1; bad = 0;
    end
    prev_start = s; prev_cfg = c; have_prev = 1;
  endtask

  initial begin
    #(5.0 * 5000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) step(0, 0, 0, 0, 8'h11);
    // R10: first cycle after reset with a new value is not compared
    step(1, 0, 0, 1, 8'h22);
    step(1, 0, 0, 0, 8'h22);
    // R2 R3: change on the start-edge cycle is skipped
    step(1, 1, 0, 1, 8'h33);
    step(1, 0, 0, 1, 8'h33);
    step(1, 0, 0, 1, 8'h33);
    step(1, 0, 1, 1, 8'h33);   // clean window, no win_fail
    // R4 R6: change mid window, report at done
    step(1, 1, 0, 1, 8'h33);
    step(1, 0, 0, 1, 8'h44);
    step(1, 0, 0, 1, 8'h44);
    step(1, 0, 1, 0, 8'h44);
    // change after done is outside the window
    step(1, 0, 0, 0, 8'h55);
    // R9: done with no window
    step(1, 0, 1, 0, 8'h55);
    step(1, 0, 1, 0, 8'h66);
    // R2: start held high, single edge; change on done cycle
    step(1, 1, 0, 0, 8'h66);
    step(1, 1, 0, 0, 8'h66);
    step(1, 1, 0, 0, 8'h66);
    step(1, 0, 1, 0, 8'h77);
    // R8: second start edge inside an open window is ignored
    step(1, 1, 0, 1, 8'h77);
    step(1, 0, 0, 1, 8'h78);
    step(1, 1, 0, 1, 8'h78);
    step(1, 0, 0, 1, 8'h78);
    step(1, 0, 1, 1, 8'h78);
    // R5: busy low changes ignored for u1
    step(1, 0, 0, 0, 8'h01);
    step(1, 0, 0, 0, 8'h02);
    step(1, 0, 0, 1, 8'h03);
    // R1 R7: reset clears sticky flags
    step(0, 0, 0, 0, 8'h03);
    step(1, 0, 0, 0, 8'h03);
    // mixed pattern sweep
    for (int i = 0; i < 200; i++)
      step(1, (i % 7) < 2, (i % 11) == 5, (i % 5) > 1, (i % 13 == 4) ? i : 8'h5a);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule